// File: doc/BRIEF.md
# Four-Way XOR Pixel Share Splitter

This block splits a stream of secret RGB pixels into four shares for XOR-based visual secret sharing. A chaotic random source supplies three bytes per beat, one from each of its x, y and z states. The block keeps a short history of these triples, so each accepted secret pixel is paired with three random pixels: the two from earlier beats and the one arriving now. It XORs the secret pixel with all three to form a combined pixel. That combined pixel, together with the three random pixels, goes out as four shares.

The share that receives the combined pixel is not fixed. Two bits of the oldest random x byte pick it, so its position moves around the four shares in a way that only someone who knows the random source can predict. The random pixels fill the other three shares in their age order. Recovery needs no key. XORing the four shares, in any order, gives back the secret pixel.

A pixel is accepted only in a beat where the random source is also valid. The block emits nothing until two random beats are already held in the history. Shares appear one clock after the accepting beat and hold their value until the next accepted pixel.

Top module: `xorShareSplitter`

## Requirements
- R1: While reset (`rstN` low) is applied and after it is released, `shareValid` is 0 and `shareData` is all zeros until the first accepted pixel.
- R2: Every clock with `rndValid` high shifts the random triple into the history, whether or not `pixValid` is high. A beat with `pixValid` low produces no output but still changes the random pixels used by later pixels.
- R3: The random pixels pack the bytes as `{x, y, z}`, with x in bits [23:16] and z in bits [7:0]. P1 is the triple from two random beats back, P2 the triple from the previous random beat, and P3 the triple arriving now. The combined pixel is secret ^ P1 ^ P2 ^ P3.
- R4: The selector is bits [17:16] of P1, which are the 2 LSBs of the oldest x byte. Share number sel+1 carries the combined pixel. The other shares carry P1, P2 and P3 in ascending share order. Share k (1..4) sits at `shareData[24*k-1 -: 24]`.
- R5: Whenever `shareValid` is high, the XOR of the four shares equals the secret pixel accepted in the previous cycle.
- R6: A pixel offered with `rndValid` high before two earlier random beats have entered the history after reset produces no output.
- R7: A pixel is accepted when `pixValid`, `rndValid` and a full history are present together in the same cycle. `shareValid` is then high exactly one cycle later, with that pixel's shares.
- R8: A pixel offered while `rndValid` is low is ignored. No output follows, and neither the shares nor the history change.
- R9: In a cycle where `shareValid` is low, `shareData` keeps the value it had in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Secret pixel present |
| secretPix | input | 24 | Secret RGB pixel, R in the high byte |
| rndValid | input | 1 | Random triple present |
| rndX | input | 8 | Random byte from the x state |
| rndY | input | 8 | Random byte from the y state |
| rndZ | input | 8 | Random byte from the z state |
| shareValid | output | 1 | Shares hold a new pixel |
| shareData | output | 96 | Four 24-bit shares, share 1 in the low slice |

## Verification
The bench drives x bytes whose low bits step through every selector value. A design that read the selector from the newest triple, or that placed the random pixels in the wrong order, would fill the wrong shares. The bench runs random-only beats between pixels; a design that shifted the history only on accepted pixels would pair later pixels with stale random pixels. It also checks the first two random beats after reset, where a design that emitted too early would output shares built from zero history. Pixels offered without random data must leave both the output and the history untouched, and long random streams confirm that the four shares always XOR back to the secret pixel.

// File: rtl/xorShareSplitPkg.sv
package xorShareSplitPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // advance random history
    logic emitEn;   // load share registers
  } splitStrobes_t;
endpackage

// File: rtl/xorShareCtrl.sv
module xorShareCtrl
  import xorShareSplitPkg::*;
#(
  parameter int NUM_SHARES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          rndValid,
  output splitStrobes_t strobes,
  output logic          outValid
);
  localparam int FILL_TARGET = NUM_SHARES - 2;
  localparam int FILL_W      = $clog2(NUM_SHARES);

  logic [FILL_W-1:0] fillCount;
  logic              histFull;

  assign histFull = (fillCount == FILL_W'(FILL_TARGET));

  always_comb begin
    strobes.shiftEn = rndValid;
    strobes.emitEn  = rndValid && pixValid && histFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
      outValid  <= 1'b0;
    end else begin
      if (rndValid && !histFull) fillCount <= fillCount + 1'b1;
      outValid <= strobes.emitEn;
    end
  end
endmodule

// File: rtl/xorShareDatapath.sv
module xorShareDatapath
  import xorShareSplitPkg::*;
#(
  parameter int CHAN_W     = 8,
  parameter int NUM_SHARES = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  splitStrobes_t                    strobes,
  input  logic [3*CHAN_W-1:0]              secretPix,
  input  logic [CHAN_W-1:0]                rndX,
  input  logic [CHAN_W-1:0]                rndY,
  input  logic [CHAN_W-1:0]                rndZ,
  output logic [NUM_SHARES*3*CHAN_W-1:0]   shareData
);
  localparam int PIX_W  = 3 * CHAN_W;
  localparam int RND_N  = NUM_SHARES - 1;
  localparam int HIST_D = NUM_SHARES - 2;
  localparam int SEL_W  = $clog2(NUM_SHARES);

  logic [PIX_W-1:0] curRnd;
  logic [PIX_W-1:0] hist    [HIST_D];
  logic [PIX_W-1:0] rndPix  [RND_N];
  logic [PIX_W-1:0] shareNext [NUM_SHARES];
  logic [PIX_W-1:0] combinedPix;
  logic [SEL_W-1:0] placeSel;
  logic [NUM_SHARES*PIX_W-1:0] shareReg;

  assign curRnd = {rndX, rndY, rndZ};

  // History: hist[0] is the oldest triple
  for (genvar i = 0; i < HIST_D; i++) begin : gHist
    always_ff @(posedge clk) begin
      if (!rstN) hist[i] <= '0;
      else if (strobes.shiftEn) begin
        if (i == HIST_D - 1) hist[i] <= curRnd;
        else                 hist[i] <= hist[(i + 1) % HIST_D];
      end
    end
    assign rndPix[i] = hist[i];
  end
  assign rndPix[RND_N-1] = curRnd;

  always_comb begin
    combinedPix = secretPix;
    for (int k = 0; k < RND_N; k++) combinedPix = combinedPix ^ rndPix[k];
  end

  // Oldest x byte low bits choose the combined pixel's share
  assign placeSel = rndPix[0][2*CHAN_W +: SEL_W];

  for (genvar j = 0; j < NUM_SHARES; j++) begin : gPlace
    if (j == 0) begin : gFirst
      assign shareNext[j] = (placeSel == SEL_W'(j)) ? combinedPix : rndPix[0];
    end else if (j == NUM_SHARES - 1) begin : gLast
      assign shareNext[j] = (placeSel == SEL_W'(j)) ? combinedPix : rndPix[j-1];
    end else begin : gMid
      assign shareNext[j] = (placeSel == SEL_W'(j)) ? combinedPix :
                            (placeSel >  SEL_W'(j)) ? rndPix[j] : rndPix[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) shareReg <= '0;
    else if (strobes.emitEn) begin
      for (int j = 0; j < NUM_SHARES; j++) shareReg[j*PIX_W +: PIX_W] <= shareNext[j];
    end
  end

  assign shareData = shareReg;
endmodule

// File: rtl/xorShareSplitter.sv
module xorShareSplitter
  import xorShareSplitPkg::*;
#(
  parameter int CHAN_W     = 8,
  parameter int NUM_SHARES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           pixValid,
  input  logic [3*CHAN_W-1:0]            secretPix,
  input  logic                           rndValid,
  input  logic [CHAN_W-1:0]              rndX,
  input  logic [CHAN_W-1:0]              rndY,
  input  logic [CHAN_W-1:0]              rndZ,
  output logic                           shareValid,
  output logic [NUM_SHARES*3*CHAN_W-1:0] shareData
);
  splitStrobes_t strobes;

  xorShareCtrl #(.NUM_SHARES(NUM_SHARES)) uCtrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .rndValid(rndValid),
    .strobes(strobes), .outValid(shareValid)
  );

  xorShareDatapath #(.CHAN_W(CHAN_W), .NUM_SHARES(NUM_SHARES)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .secretPix(secretPix),
    .rndX(rndX), .rndY(rndY), .rndZ(rndZ), .shareData(shareData)
  );
endmodule

// File: rtl/xorShareSplitterChk.sv
module xorShareSplitterChk #(
  parameter int CHAN_W     = 8,
  parameter int NUM_SHARES = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           pixValid,
  input logic [3*CHAN_W-1:0]            secretPix,
  input logic                           rndValid,
  input logic                           shareValid,
  input logic [NUM_SHARES*3*CHAN_W-1:0] shareData
);
  localparam int PIX_W  = 3 * CHAN_W;
  localparam int FILL   = NUM_SHARES - 2;
  localparam int BEAT_W = $clog2(NUM_SHARES);

  logic [BEAT_W-1:0] rndBeats;
  logic [PIX_W-1:0]  shareXor;
  logic              ready;

  always_ff @(posedge clk) begin
    if (!rstN) rndBeats <= '0;
    else if (rndValid && (rndBeats != BEAT_W'(FILL))) rndBeats <= rndBeats + 1'b1;
  end
  assign ready = (rndBeats == BEAT_W'(FILL));

  always_comb begin
    shareXor = '0;
    for (int j = 0; j < NUM_SHARES; j++) shareXor = shareXor ^ shareData[j*PIX_W +: PIX_W];
  end

  assert_recover_R5: assert property (@(posedge clk) disable iff (!rstN)
    shareValid |-> (shareXor == $past(secretPix)));

  assert_no_early_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && rndValid && !ready) |=> !shareValid);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && rndValid && ready) |=> shareValid);

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && rndValid) |=> !shareValid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !shareValid |-> $stable(shareData));
endmodule

bind xorShareSplitter xorShareSplitterChk #(.CHAN_W(CHAN_W), .NUM_SHARES(NUM_SHARES)) uChk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .secretPix(secretPix),
  .rndValid(rndValid), .shareValid(shareValid), .shareData(shareData)
);

// File: tb/sim_xorShareSplitter.sv
`timescale 1ns/1ps
module sim_xorShareSplitter;
  localparam int PW = 24;
  localparam int TW = 96;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pixValid = 1'b0;
  logic [PW-1:0] secretPix = '0;
  logic          rndValid = 1'b0;
  logic [7:0]    rndX = '0, rndY = '0, rndZ = '0;
  logic          shareValid;
  logic [TW-1:0] shareData;

  int checks = 0;
  int errors = 0;

  logic [PW-1:0] mHist [2];
  int            mFill;
  logic [TW-1:0] lastShares;

  always #4 clk = ~clk;

  xorShareSplitter u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .secretPix(secretPix),
    .rndValid(rndValid), .rndX(rndX), .rndY(rndY), .rndZ(rndZ),
    .shareValid(shareValid), .shareData(shareData)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected shares from the requirement text (R3, R4)
  function automatic logic [TW-1:0] modelShares(input logic [PW-1:0] pix,
                                                input logic [PW-1:0] cur);
    logic [PW-1:0] r [3];
    logic [PW-1:0] comb;
    logic [TW-1:0] res;
    int sel, k;
    r[0] = mHist[0]; r[1] = mHist[1]; r[2] = cur;
    comb = pix ^ r[0] ^ r[1] ^ r[2];
    sel  = int'(r[0][17:16]);
    k = 0;
    res = '0;
    for (int j = 0; j < 4; j++) begin
      if (j == sel) res[j*PW +: PW] = comb;
      else begin res[j*PW +: PW] = r[k]; k++; end
    end
    return res;
  endfunction

  task automatic doBeat(input logic pv, input logic rv, input logic [PW-1:0] pix,
                        input logic [PW-1:0] rnd, input string req);
    logic          expValid;
    logic [TW-1:0] expData;
    logic [PW-1:0] xr;
    @(negedge clk);
    pixValid = pv; rndValid = rv; secretPix = pix; {rndX, rndY, rndZ} = rnd;
    expValid = pv && rv && (mFill == 2);
    expData  = expValid ? modelShares(pix, rnd) : lastShares;
    if (rv) begin
      if (mFill < 2) mFill++;
      mHist[0] = mHist[1];
      mHist[1] = rnd;
    end
    @(posedge clk); #1;
    checkVal(req, "shareValid", TW'(shareValid), TW'(expValid));
    checkVal(req, "shareData", shareData, expData);
    if (shareValid) begin
      xr = '0;
      for (int j = 0; j < 4; j++) xr = xr ^ shareData[j*PW +: PW];
      checkVal("R5", "share xor", TW'(xr), TW'(pix));
    end
    lastShares = expData;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; pixValid = 1'b0; rndValid = 1'b0;
    mHist[0] = '0; mHist[1] = '0; mFill = 0; lastShares = '0;
    repeat (2) @(posedge clk);
    #1;
    checkVal("R1", "valid in reset", TW'(shareValid), '0);
    checkVal("R1", "data in reset", shareData, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkVal("R1", "valid after reset", TW'(shareValid), '0);
    checkVal("R1", "data after reset", shareData, '0);
  endtask

  task automatic testFill();  // R6, R7
    applyReset();
    doBeat(1'b1, 1'b1, 24'h123456, 24'h0A1B2C, "R6");
    doBeat(1'b1, 1'b1, 24'h654321, 24'h3D4E5F, "R6");
    doBeat(1'b1, 1'b1, 24'hABCDEF, 24'h778899, "R7");
    doBeat(1'b0, 1'b0, 24'h0, 24'h0, "R7");
  endtask

  task automatic testPlacement();  // R3, R4: each selector value
    applyReset();
    for (int i = 0; i < 10; i++)
      doBeat(1'b1, 1'b1, 24'hC0FFEE ^ PW'(i * 24'h010203),
             {6'(i * 5 + 17), 2'(i), 8'(8'h5A + i), 8'(8'hA5 - i)}, "R3/R4");
  endtask

  task automatic testShiftOnly();  // R2
    doBeat(1'b0, 1'b1, 24'hFFFFFF, 24'h010101, "R2");
    doBeat(1'b0, 1'b1, 24'hFFFFFF, 24'h020202, "R2");
    doBeat(1'b1, 1'b1, 24'h112233, 24'h030303, "R2");
    doBeat(1'b0, 1'b1, 24'h0, 24'h4C4C4C, "R2");
    doBeat(1'b1, 1'b1, 24'h445566, 24'h070809, "R2");
  endtask

  task automatic testIgnore();  // R8
    doBeat(1'b1, 1'b0, 24'hDEAD00, 24'hFEFEFE, "R8");
    doBeat(1'b1, 1'b0, 24'h00BEEF, 24'h010203, "R8");
    doBeat(1'b1, 1'b1, 24'h778899, 24'h0F0F0F, "R8");
  endtask

  task automatic testHold();  // R9
    doBeat(1'b0, 1'b0, 24'h0, 24'h0, "R9");
    doBeat(1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF, "R9");
    doBeat(1'b0, 1'b0, 24'h0, 24'h0, "R9");
  endtask

  task automatic testRandom();  // R5 on random streams
    applyReset();
    for (int i = 0; i < 400; i++)
      doBeat(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) != 0),
             PW'($urandom), PW'($urandom), "R5");
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mHist[0] = '0; mHist[1] = '0; mFill = 0; lastShares = '0;
    testFill();
    testPlacement();
    testShiftOnly();
    testIgnore();
    testHold();
    testRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule